// File: doc/BRIEF.md
# Virtual-Channel Class Selector for Deadlock-Free Routing

This block decides which virtual channels (VCs) a packet may ask for on its next hop. Each packet carries a one-bit buffer class in its head flit. Traffic moves from class 0 to class 1 when a policy event occurs on the current hop. A mode input picks the policy. Once a packet is in class 1 it never returns to class 0. Because every route acquires buffer classes in ascending order, the extended channel dependence graph stays acyclic.

The selector turns the resulting class into a mask of permitted VCs. The two class masks may overlap, so that class-1 buffers are not left idle by packets that never change class. Each class still keeps at least one VC that belongs to it alone. Head flits compute a new class. Body and tail flits reuse the head's result. The output is registered one cycle after the input flit. Route computation, the VC allocator and the buffers sit outside this block.

Top module: `vc_class_sel`

## Requirements
- R1: While rst_n is low and on the first cycle after it, out_valid is 0, out_class is 0 and out_mask is all zeros.
- R2: In mode 0 (ring), a head flit leaves with class 1 if its current class is 1 or in_dateline is set, otherwise with class 0.
- R3: In mode 1 (two-phase oblivious), a head flit of a YX-routed packet (in_yx = 1) leaves with class 1, and an XY-routed one (in_yx = 0, current class 0) with class 0.
- R4: In mode 2 (turn-based adaptive), a head flit leaves with class 1 once in_turn is set or its current class is 1, otherwise with class 0.
- R5: In mode 3 (randomized two-phase), a head flit leaves with class 1 when in_at_mid is set or its current class is 1, otherwise with class 0.
- R6: A head flit arriving with class 1 always leaves with class 1, in every mode and under every flag value.
- R7: With the default parameters (4 VCs, class 0 top VC 2, class 1 bottom VC 2), class 0 gives out_mask 4'b0111 and class 1 gives out_mask 4'b1100. VC 2 is shared, VCs 0 and 1 belong only to class 0, and VC 3 belongs only to class 1.
- R8: Flags that do not belong to the selected mode have no effect on the output class.
- R9: A valid non-head flit (in_head = 0) leaves with the class and mask of the most recent head flit, whatever its own class, mode and flags are.
- R10: out_valid equals in_valid one clock earlier. A cycle with no valid output gives an all-zero mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A flit is presented this cycle |
| in_head | input | 1 | The flit is a head flit |
| in_class | input | 1 | Buffer class carried by the head flit |
| in_mode | input | 2 | Policy: 0 ring, 1 oblivious, 2 adaptive, 3 randomized two-phase |
| in_dateline | input | 1 | This hop crosses the ring dateline |
| in_turn | input | 1 | This hop takes a turn |
| in_yx | input | 1 | The packet is routed YX rather than XY |
| in_at_mid | input | 1 | The packet has reached its intermediate node |
| out_valid | output | 1 | Registered result is valid |
| out_class | output | 1 | Class for the next hop |
| out_mask | output | NUM_VC | VCs the flit may request |

## Verification
The hardest case to reach is a body flit whose own fields would choose a different class than its head. This only happens when the fields change in the middle of a packet. The bench sends a head flit, then body flits whose class, mode and flags all point the other way. It checks that the mask stays the head's. It also sends a head whose class is 1 under every mode with all flags clear, to show that the class never drops back to 0.

// File: rtl/vc_class_pkg.sv
// Shared types for the VC class selector.
// Assumes two buffer classes; the class is one bit wide.
package vc_class_pkg;
    typedef enum logic [1:0] {
        POL_RING      = 2'd0,
        POL_OBLIVIOUS = 2'd1,
        POL_ADAPTIVE  = 2'd2,
        POL_TWO_PHASE = 2'd3
    } policy_e;
endpackage

// File: rtl/vc_class_policy.sv
// Next-class decision for one head flit.
// Assumes the flag inputs describe the current hop. The class can only
// rise, because each policy event is ORed onto the current class.
module vc_class_policy
    import vc_class_pkg::*;
(
    input  logic    cur_class,
    input  policy_e mode,
    input  logic    dateline,
    input  logic    turn,
    input  logic    yx,
    input  logic    at_mid,
    output logic    nxt_class
);
    logic promote;

    // Pick the single event that matters under the active policy.
    always_comb begin
        case (mode)
            POL_RING:      promote = dateline;
            POL_OBLIVIOUS: promote = yx;
            POL_ADAPTIVE:  promote = turn;
            default:       promote = at_mid;
        endcase
    end

    // Classes are acquired in ascending order only.
    always_comb nxt_class = cur_class | promote;
endmodule

// File: rtl/vc_class_mask.sv
// Maps a class to the mask of VCs it may request.
// Assumes C1_BOT <= C0_TOP + 1, so that no VC is left unused, and
// C1_BOT > 0 and C0_TOP < NUM_VC-1, so that each class keeps a VC of its own.
module vc_class_mask #(
    parameter int NUM_VC = 4,
    parameter int C0_TOP = 2,
    parameter int C1_BOT = 2
) (
    input  logic              cls,
    output logic [NUM_VC-1:0] mask
);
    logic [NUM_VC-1:0] mask_c0;
    logic [NUM_VC-1:0] mask_c1;

    // Build one bit of each class's VC window per channel.
    for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
        assign mask_c0[v] = (v <= C0_TOP);
        assign mask_c1[v] = (v >= C1_BOT);
    end

    // Select the window of the requested class.
    always_comb mask = cls ? mask_c1 : mask_c0;
endmodule

// File: rtl/vc_class_sel.sv
// VC class selector, top level.
// Head flits get a new class from the active policy. Body and tail flits
// reuse the class and mask held from their head. All results are
// registered, so the output appears one cycle after the input flit.
// Assumes flits of a packet arrive in order with no interleaving.
module vc_class_sel
    import vc_class_pkg::*;
#(
    parameter int NUM_VC = 4,
    parameter int C0_TOP = 2,
    parameter int C1_BOT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_head,
    input  logic              in_class,
    input  logic [1:0]        in_mode,
    input  logic              in_dateline,
    input  logic              in_turn,
    input  logic              in_yx,
    input  logic              in_at_mid,
    output logic              out_valid,
    output logic              out_class,
    output logic [NUM_VC-1:0] out_mask
);
    logic              head_class;
    logic [NUM_VC-1:0] head_mask;
    logic              held_class;
    logic [NUM_VC-1:0] held_mask;

    vc_class_policy u_policy (
        .cur_class (in_class),
        .mode      (policy_e'(in_mode)),
        .dateline  (in_dateline),
        .turn      (in_turn),
        .yx        (in_yx),
        .at_mid    (in_at_mid),
        .nxt_class (head_class)
    );

    vc_class_mask #(
        .NUM_VC (NUM_VC),
        .C0_TOP (C0_TOP),
        .C1_BOT (C1_BOT)
    ) u_mask (
        .cls  (head_class),
        .mask (head_mask)
    );

    // Remember the head's decision for the rest of its packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_class <= 1'b0;
            held_mask  <= '0;
        end else if (in_valid && in_head) begin
            held_class <= head_class;
            held_mask  <= head_mask;
        end
    end

    // Register the output for each flit; drive zeros when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_class <= 1'b0;
            out_mask  <= '0;
        end else if (!in_valid) begin
            out_valid <= 1'b0;
            out_class <= 1'b0;
            out_mask  <= '0;
        end else if (in_head) begin
            out_valid <= 1'b1;
            out_class <= head_class;
            out_mask  <= head_mask;
        end else begin
            out_valid <= 1'b1;
            out_class <= held_class;
            out_mask  <= held_mask;
        end
    end

    // R6: a head already in class 1 is never sent back to class 0.
    a_r6_no_demote: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_head && in_class |=> out_class);

    // R10: the output valid follows the input valid by one cycle.
    a_r10_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> out_valid == $past(in_valid));

    // R10: an idle output cycle gives an empty mask.
    a_r10_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_mask == '0);

    // R7: a class-1 result never grants the lowest VC, which belongs to class 0.
    a_r7_c1_no_vc0: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_class |-> !out_mask[0]);

    // R7: a class-0 result never grants the top VC, which belongs to class 1.
    a_r7_c0_no_top: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_class |-> !out_mask[NUM_VC-1]);

    // R9: a body flit after a valid flit keeps the same mask.
    a_r9_body_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_head && out_valid |=> out_mask == $past(out_mask));
endmodule

// File: tb/vc_class_sel_tb.sv
module vc_class_sel_tb;
    localparam int NUM_VC = 4;
    localparam logic [3:0] MASK0 = 4'b0111;
    localparam logic [3:0] MASK1 = 4'b1100;
    localparam int NVEC = 16;
    // {cur, mode[1:0], dateline, turn, yx, at_mid, expected class}
    localparam logic [7:0] VEC [NVEC] = '{
        8'b0_00_0000_0, 8'b0_00_1000_1, 8'b1_00_0000_1, 8'b0_00_0111_0,
        8'b0_01_0000_0, 8'b0_01_0010_1, 8'b1_01_0000_1, 8'b0_01_1101_0,
        8'b0_10_0000_0, 8'b0_10_0100_1, 8'b1_10_0000_1, 8'b0_10_1011_0,
        8'b0_11_0000_0, 8'b0_11_0001_1, 8'b1_11_0000_1, 8'b0_11_1110_0
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_head = 1'b0, in_class = 1'b0;
    logic [1:0] in_mode = 2'd0;
    logic in_dateline = 1'b0, in_turn = 1'b0, in_yx = 1'b0, in_at_mid = 1'b0;
    logic out_valid, out_class;
    logic [NUM_VC-1:0] out_mask;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vc_class_sel #(.NUM_VC(NUM_VC)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_head(in_head),
        .in_class(in_class), .in_mode(in_mode), .in_dateline(in_dateline),
        .in_turn(in_turn), .in_yx(in_yx), .in_at_mid(in_at_mid),
        .out_valid(out_valid), .out_class(out_class), .out_mask(out_mask)
    );

    task automatic check(input string req, input logic [5:0] got, input logic [5:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: {valid,class,mask} actual %b expected %b", req, got, exp);
        end
    endtask

    // Drive one flit at a falling edge; results are checked at the next falling edge.
    task automatic send(input logic v, input logic h, input logic [7:0] f);
        @(negedge clk);
        in_valid = v; in_head = h; in_class = f[7]; in_mode = f[6:5];
        in_dateline = f[4]; in_turn = f[3]; in_yx = f[2]; in_at_mid = f[1];
        @(negedge clk);
    endtask

    function automatic logic [5:0] expect_out(input logic c);
        return {1'b1, c, c ? MASK1 : MASK0};
    endfunction

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", {out_valid, out_class, out_mask}, 6'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {out_valid, out_class, out_mask}, 6'b0);

        // Table walk: R2..R5 by mode, R6 for class-1 heads, R8 for stray flags
        for (int i = 0; i < NVEC; i++) begin
            string tag;
            send(1'b1, 1'b1, VEC[i]);
            if (VEC[i][7]) tag = "R6";
            else if (VEC[i][4:1] != 4'b0 && VEC[i][0] == 1'b0) tag = "R8";
            else case (VEC[i][6:5])
                2'd0: tag = "R2";
                2'd1: tag = "R3";
                2'd2: tag = "R4";
                default: tag = "R5";
            endcase
            check(tag, {out_valid, out_class, out_mask}, expect_out(VEC[i][0]));
        end

        // R7: explicit masks for each class
        send(1'b1, 1'b1, 8'b0_00_0000_0);
        check("R7", {2'b00, out_mask}, {2'b00, MASK0});
        send(1'b1, 1'b1, 8'b0_00_1000_0);
        check("R7", {2'b00, out_mask}, {2'b00, MASK1});

        // R9: body flits ignore their own fields after a class-1 head
        send(1'b1, 1'b1, 8'b0_11_0001_0);
        send(1'b1, 1'b0, 8'b0_00_0000_0);
        check("R9", {out_valid, out_class, out_mask}, expect_out(1'b1));
        send(1'b1, 1'b0, 8'b0_10_0000_0);
        check("R9", {out_valid, out_class, out_mask}, expect_out(1'b1));
        // R9: body after a class-0 head ignores promoting flags
        send(1'b1, 1'b1, 8'b0_01_0000_0);
        send(1'b1, 1'b0, 8'b1_00_1111_0);
        check("R9", {out_valid, out_class, out_mask}, expect_out(1'b0));

        // R10: idle cycle, then a body flit still uses the held head result
        send(1'b0, 1'b0, 8'b1_00_1111_0);
        check("R10", {out_valid, out_class, out_mask}, 6'b0);
        send(1'b1, 1'b0, 8'b1_11_1111_0);
        check("R9", {out_valid, out_class, out_mask}, expect_out(1'b0));

        // R1: reset asserted mid-stream clears the output
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b1; in_head = 1'b1; in_class = 1'b1;
        @(negedge clk);
        check("R1", {out_valid, out_class, out_mask}, 6'b0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule